// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block gathers interrupt events from peripheral sources into latched pending bits, one bit per source. It pairs each pending bit with an enable bit and signals a maskable interrupt request to a 4-bit processor core. The request is raised only when at least one pending bit has its enable bit set and the core's global interrupt enable input is high. Software reaches both banks over a small register bus with a 16-bit address and 4-bit data. A pending bit is cleared by writing 1 to its position. A separate non-maskable request from the watchdog passes straight through, with no pending bit and no gating.

Eight periodic clock-divider taps are built in as sources. Each one latches its pending bit when its tap falls from high to low. The other sources arrive as one-cycle event pulses. The register bus is a plain strobed bus: writes take effect on the clock edge where the write strobe is high, reads are combinational from the address, and the bus has no stall or back-pressure.

Top module: `irq_flag_ctrl`

## Requirements
- R1: An event pulse on an implemented bit of `evt_i` sets its pending bit at the next clock edge, and the bit stays set until it is cleared. Bit k of nibble n (n = 1..13) is `evt_i[(n-1)*4+k]`.
- R2: Writing a nibble to pending address 0xFFF0+n clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: When an event and a write-1 clear reach the same pending bit in the same cycle, the bit ends up set.
- R4: Reset (active-low `rst_n`) clears all pending bits, all enable bits and `irq_o`.
- R5: Enable nibble n sits at address 0xFFE0+n and is read/write. Each bit controls the pending bit at the same position of nibble n, where 1 enables the source and 0 blocks it.
- R6: `irq_o` goes high one cycle after a cycle in which `gie_i` is 1 and some pending bit and its enable bit are both 1. It stays low when any of these three is missing.
- R7: `irq_o` goes low in the cycle after the last enabled pending bit is cleared.
- R8: When `gie_i` drops, `irq_o` goes low one cycle later. If an enabled pending bit is still set, `irq_o` rises again one cycle after `gie_i` returns to 1.
- R9: `nmi_o` follows `wdt_i` in the same cycle, whatever the enable bits, the pending bits and `gie_i` are.
- R10: A falling edge on `tap_i[j]` sets a pending bit, and a rising edge sets nothing. Taps 0..3 (128, 64, 32, 16 Hz) map to bits 0..3 of nibble 14 (0xFFFE). Taps 4..7 (8, 4, 2, 1 Hz) map to bits 0..3 of nibble 15 (0xFFFF).
- R11: The following read as 0 and ignore writes: unimplemented bits, offset 0 of each bank, and any address outside pages 0xFFE_ and 0xFFF_. With the default map, nibble 1 implements bits 0..2 and nibbles 6..9 implement no bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 52 | One-cycle event pulses, nibbles 1..13 |
| tap_i | input | 8 | Clock-divider taps, latched on falling edge |
| wdt_i | input | 1 | Watchdog non-maskable request |
| gie_i | input | 1 | Core global interrupt enable |
| bus_addr_i | input | 16 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 4 | Write data |
| bus_rdata_o | output | 4 | Read data, combinational from address |
| irq_o | output | 1 | Registered maskable interrupt request |
| nmi_o | output | 1 | Non-maskable request |

## Verification
The request path is driven through each combination that has one of its three terms missing: pending without enable, pending and enable without global enable, and all three present. This separates a missing AND term from a working gate. Clears are tested with write-0, with write-1, and with a write-1 that lands in the same cycle as a new event, which tells clear-wins apart from set-wins. The taps are toggled both ways to show that rising edges are ignored. Enable bits in an unimplemented nibble, at offset 0 and on a foreign page are written and read back to show that those locations hold nothing.

// File: rtl/irq_fc_pkg.sv
package irq_fc_pkg;
  localparam int NIB_W      = 4;
  localparam int ADDR_W     = 16;
  localparam int N_EVT_REG  = 13;
  localparam int N_TAP      = 8;
  localparam logic [11:0] FLAG_PAGE = 12'hFFF;
  localparam logic [11:0] MASK_PAGE = 12'hFFE;
  // per-nibble implemented bits, nibble 13 down to nibble 1
  localparam logic [N_EVT_REG*NIB_W-1:0] EVT_IMPL_DEF = 52'hFFF1000033337;
endpackage

// File: rtl/irq_tap_fall.sv
module irq_tap_fall #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tap_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] tap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= '0;
    else        tap_q <= tap_i;
  end

  assign fall_o = tap_q & ~tap_i;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int          N    = 60,
  parameter logic [N-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mwe_i,
  input  logic [N-1:0] mdat_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] flag_q, mask_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= ((flag_q & ~clr_i) | set_i) & IMPL;
      mask_q <= ((mask_q & ~mwe_i) | (mdat_i & mwe_i)) & IMPL;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int N = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] mask_i,
  input  logic         gie_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gie_i & |(flag_i & mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_fc_pkg::*;
#(
  parameter int ADDR_W_P   = ADDR_W,
  parameter int NIB_W_P    = NIB_W,
  parameter int N_EVT_REG_P = N_EVT_REG,
  parameter int N_TAP_P    = N_TAP,
  parameter logic [N_EVT_REG_P*NIB_W_P-1:0] EVT_IMPL = EVT_IMPL_DEF,
  parameter logic [ADDR_W_P-5:0] FLAG_PG = FLAG_PAGE,
  parameter logic [ADDR_W_P-5:0] MASK_PG = MASK_PAGE
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_EVT_REG_P*NIB_W_P-1:0]   evt_i,
  input  logic [N_TAP_P-1:0]               tap_i,
  input  logic                             wdt_i,
  input  logic                             gie_i,
  input  logic [ADDR_W_P-1:0]              bus_addr_i,
  input  logic                             bus_wr_i,
  input  logic [NIB_W_P-1:0]               bus_wdata_i,
  output logic [NIB_W_P-1:0]               bus_rdata_o,
  output logic                             irq_o,
  output logic                             nmi_o
);
  localparam int SEL_W  = 4;
  localparam int N_EVT  = N_EVT_REG_P * NIB_W_P;
  localparam int N_REG  = N_EVT_REG_P + N_TAP_P / NIB_W_P;
  localparam int N_FLAG = N_REG * NIB_W_P;
  localparam logic [N_FLAG-1:0] IMPL_ALL = {{N_TAP_P{1'b1}}, EVT_IMPL};

  logic [N_TAP_P-1:0] tap_fall;
  logic [N_FLAG-1:0]  set_v, clr_v, mwe_v, mdat_v, flag_q, mask_q;
  logic [N_REG-1:0]   reg_hit;
  logic               flag_pg, mask_pg;
  logic [SEL_W-1:0]   sel;

  assign flag_pg = (bus_addr_i[ADDR_W_P-1:SEL_W] == FLAG_PG);
  assign mask_pg = (bus_addr_i[ADDR_W_P-1:SEL_W] == MASK_PG);
  assign sel     = bus_addr_i[SEL_W-1:0];

  irq_tap_fall #(.W(N_TAP_P)) u_tap (
    .clk(clk), .rst_n(rst_n), .tap_i(tap_i), .fall_o(tap_fall)
  );

  assign set_v = {tap_fall, evt_i};

  // per-nibble write decode; offset 0 of each page is left unmapped
  for (genvar r = 0; r < N_REG; r++) begin : g_dec
    assign reg_hit[r] = (sel == SEL_W'(r + 1));
    assign clr_v[r*NIB_W_P +: NIB_W_P] =
      (bus_wr_i && flag_pg && reg_hit[r]) ? bus_wdata_i : '0;
    assign mwe_v[r*NIB_W_P +: NIB_W_P] = {NIB_W_P{bus_wr_i && mask_pg && reg_hit[r]}};
    assign mdat_v[r*NIB_W_P +: NIB_W_P] = bus_wdata_i;
  end

  irq_flag_bank #(.N(N_FLAG), .IMPL(IMPL_ALL)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v),
    .mwe_i(mwe_v), .mdat_i(mdat_v), .flag_o(flag_q), .mask_o(mask_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (reg_hit[r]) begin
        if (flag_pg)      bus_rdata_o = flag_q[r*NIB_W_P +: NIB_W_P];
        else if (mask_pg) bus_rdata_o = mask_q[r*NIB_W_P +: NIB_W_P];
      end
    end
  end

  irq_req_gen #(.N(N_FLAG)) u_req (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_q), .mask_i(mask_q),
    .gie_i(gie_i), .irq_o(irq_o)
  );

  assign nmi_o = wdt_i;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int           N      = 60,
  parameter logic [N-1:0] IMPL   = '1,
  parameter int           ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gie_i,
  input logic              irq_o,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [3:0]        bus_rdata_o,
  input logic [N-1:0]      set_v,
  input logic [N-1:0]      flag_q,
  input logic [N-1:0]      mask_q
);
  p_reset_state_r4: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && flag_q == '0 && mask_q == '0));

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_v & IMPL) |=> ((flag_q & $past(set_v & IMPL)) == $past(set_v & IMPL)));

  p_gie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(gie_i) && $past(|(flag_q & mask_q))));

  p_drop_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & mask_q) == '0) |=> !irq_o);

  p_gie_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> !irq_o);

  p_foreign_page_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i[ADDR_W-1:4] != 12'hFFF && bus_addr_i[ADDR_W-1:4] != 12'hFFE)
      |-> (bus_rdata_o == 4'h0));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
  .N(N_FLAG), .IMPL(IMPL_ALL), .ADDR_W(ADDR_W_P)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .irq_o(irq_o),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .set_v(set_v), .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] evt_i = '0;
  logic [7:0]  tap_i = 8'hFF;
  logic        wdt_i = 1'b0;
  logic        gie_i = 1'b0;
  logic [15:0] bus_addr_i = 16'h0000;
  logic        bus_wr_i = 1'b0;
  logic [3:0]  bus_wdata_i = 4'h0;
  logic [3:0]  bus_rdata_o;
  logic        irq_o, nmi_o;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    int         kind;   // 0 read data, 1 irq, 2 nmi
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  irq_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .tap_i(tap_i), .wdt_i(wdt_i),
    .gie_i(gie_i), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o), .nmi_o(nmi_o)
  );

  // monitor: pops expectations queued during the current low phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it = sb.pop_front();
        case (it.kind)
          0:       act = bus_rdata_o;
          1:       act = {3'b0, irq_o};
          default: act = {3'b0, nmi_o};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_rd(input logic [15:0] a, input logic [3:0] e, input string tag);
    bus_addr_i = a;
    sb.push_back('{0, e, tag});
    tick();
  endtask

  task automatic chk_irq(input logic e, input string tag);
    sb.push_back('{1, {3'b0, e}, tag});
    tick();
  endtask

  task automatic chk_nmi(input logic e, input string tag);
    sb.push_back('{2, {3'b0, e}, tag});
    tick();
  endtask

  task automatic wr(input logic [15:0] a, input logic [3:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    tick();
    bus_wr_i = 1'b0;
  endtask

  task automatic pulse(input int idx);
    evt_i[idx] = 1'b1;
    tick();
    evt_i = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R4: reset state
    chk_rd(16'hFFF1, 4'h0, "R4 flags clear");
    chk_rd(16'hFFE1, 4'h0, "R4 masks clear");
    chk_irq(1'b0, "R4 irq low");

    // R1: event pulses latch
    pulse(0);
    chk_rd(16'hFFF1, 4'h1, "R1 nibble1 bit0");
    pulse(42);
    chk_rd(16'hFFFB, 4'h4, "R1 nibble11 bit2");
    chk_rd(16'hFFF1, 4'h1, "R1 bit held");

    // R5 / R11: mask read-back with implemented bits only
    wr(16'hFFE1, 4'hF);
    chk_rd(16'hFFE1, 4'h7, "R5 mask nibble1");
    wr(16'hFFE6, 4'hF);
    chk_rd(16'hFFE6, 4'h0, "R11 empty nibble");
    wr(16'hFFE0, 4'hF);
    chk_rd(16'hFFE0, 4'h0, "R11 offset0");
    wr(16'hFFD1, 4'hF);
    chk_rd(16'hFFD1, 4'h0, "R11 foreign page");
    chk_rd(16'hFFE1, 4'h7, "R11 foreign write no alias");

    // R6: gie gating
    chk_irq(1'b0, "R6 no gie");
    gie_i = 1'b1;
    tick();
    chk_irq(1'b1, "R6 all terms set");

    // R8: gie drop and return
    gie_i = 1'b0;
    tick();
    chk_irq(1'b0, "R8 gie dropped");
    gie_i = 1'b1;
    tick();
    chk_irq(1'b1, "R8 gie returned");

    // R2: write-0 keeps, write-1 clears; R7 irq drops one cycle later
    wr(16'hFFF1, 4'h0);
    chk_rd(16'hFFF1, 4'h1, "R2 write0 keeps");
    wr(16'hFFF1, 4'h1);
    chk_irq(1'b1, "R7 irq still high at clear");
    chk_irq(1'b0, "R7 irq low after clear");
    chk_rd(16'hFFF1, 4'h0, "R2 write1 clears");
    chk_rd(16'hFFFB, 4'h4, "R6 unmasked flag kept");
    chk_irq(1'b0, "R6 pending without mask");

    // R3: set beats clear in the same cycle
    evt_i[0] = 1'b1;
    wr(16'hFFF1, 4'h1);
    evt_i = '0;
    chk_rd(16'hFFF1, 4'h1, "R3 set wins");
    wr(16'hFFF1, 4'h1);
    gie_i = 1'b0;
    tick();

    // R10: tap falling edges
    tap_i[1] = 1'b0;
    tick();
    chk_rd(16'hFFFE, 4'h2, "R10 64Hz tap fall");
    tap_i[6] = 1'b0;
    tick();
    chk_rd(16'hFFFF, 4'h4, "R10 2Hz tap fall");
    wr(16'hFFFE, 4'hF);
    tap_i[1] = 1'b1;
    tick();
    tick();
    chk_rd(16'hFFFE, 4'h0, "R10 rise ignored");

    // R5: paired mask in nibble 15 raises irq
    gie_i = 1'b1;
    wr(16'hFFEF, 4'h4);
    tick();
    chk_irq(1'b1, "R5 nibble15 mask pairs bit2");

    // R9: nmi passes regardless
    gie_i = 1'b0;
    wdt_i = 1'b1;
    chk_nmi(1'b1, "R9 nmi high");
    wdt_i = 1'b0;
    chk_nmi(1'b0, "R9 nmi low");

    repeat (2) tick();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule